// File: doc/BRIEF.md
# Configuration Request Serializer with Retry

This block feeds a transaction-layer transmit path on the root-complex side of a PCI Express port. Requesters hand it configuration reads and writes (type 0 or type 1) and I/O requests through a small in-order queue. It turns each one into a header: format, type, tag, packed address and write payload. The block keeps exactly one request in flight. After a header is accepted downstream, nothing else is sent until that request has been answered by a matching completion or has timed out, and its response has been taken by the requester.

Completions are matched on tag. Any completion whose tag differs from the outstanding one is discarded. A completion carrying the configuration retry status is handled according to the request direction. A write is sent again at once, with a fresh timeout. A read goes back to the tail of the queue, so other waiting requests are served first. Any other status ends the request and is reported on the response port. When no matching completion arrives within the programmed number of cycles, the request ends with a timeout response. When the port is strapped as an endpoint, configuration requests taken from the queue are refused locally and never reach the link.

Top module: `cfg_serializer`

## Requirements
- R1: The header type is 5'b00100 for a type 0 configuration request (req_kind_i = 2'd0), 5'b00101 for type 1 (2'd1) and 5'b00010 for I/O (2'd2).
- R2: tx_fmt_o is 3'b010 for a write and 3'b000 for a read. tx_data_o carries the request's write data for a write and is zero for a read.
- R3: tx_addr_o is {bus[7:0], device[4:0], function[2:0], 4'b0000, register[9:0], 2'b00}, and tx_tag_o equals the request tag.
- R4: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and every header field stays unchanged.
- R5: Once a header is accepted, no further header is offered until the request's response has been accepted on the response port.
- R6: Completion status codes are SC 3'b000, UR 3'b001, CRS 3'b010 and CA 3'b100. A completion whose tag differs from the outstanding tag is dropped and produces no response.
- R7: A CRS completion to a write makes the same header be offered again, and the timeout restarts from the new issue.
- R8: A CRS completion to a read places that read behind all requests already queued. It is issued again after those requests.
- R9: With a limit L on cpl_timeout_i (0 acts as 1), a matching completion is accepted only within the first L cycles after the issuing handshake edge. Otherwise the response becomes valid L clock edges after that edge, with rsp_timeout_o = 1, status CA and zero data.
- R10: With rc_mode_i low, a configuration request taken from the queue is answered with status UR and no header. I/O requests are still issued.
- R11: A non-CRS matching completion yields a response carrying the request tag and the completion status. rsp_data_o carries the completion data only for a read with status SC, and is zero otherwise. The response is held until rsp_ready_i.
- R12: req_ready_o is low when queued plus in-flight requests equal DEPTH. Requests are issued in arrival order.
- R13: After reset tx_valid_o and rsp_valid_o are low and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rc_mode_i | input | 1 | 1 = root complex, 0 = endpoint |
| cpl_timeout_i | input | TO_W | Completion timeout limit in cycles |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_kind_i | input | 2 | 0 cfg type 0, 1 cfg type 1, 2 I/O |
| req_write_i | input | 1 | 1 = write |
| req_bus_i | input | 8 | Bus number |
| req_dev_i | input | 5 | Device number |
| req_func_i | input | 3 | Function number |
| req_reg_i | input | 10 | Dword register number |
| req_tag_i | input | 8 | Request tag |
| req_data_i | input | 32 | Write data |
| tx_valid_o | output | 1 | Header offered |
| tx_ready_i | input | 1 | Header accepted |
| tx_fmt_o | output | 3 | Header format |
| tx_type_o | output | 5 | Header type |
| tx_tag_o | output | 8 | Header tag |
| tx_addr_o | output | 32 | Packed address |
| tx_data_o | output | 32 | Write payload |
| cpl_valid_i | input | 1 | Completion present |
| cpl_tag_i | input | 8 | Completion tag |
| cpl_status_i | input | 3 | Completion status |
| cpl_data_i | input | 32 | Completion data |
| rsp_valid_o | output | 1 | Response offered |
| rsp_ready_i | input | 1 | Response accepted |
| rsp_tag_o | output | 8 | Response tag |
| rsp_status_o | output | 3 | Response status |
| rsp_data_o | output | 32 | Response read data |
| rsp_timeout_o | output | 1 | Request ended by timeout |

## Verification
The bench uses the default queue depth of 4 and an 8-bit timeout counter. With depth 4, the ready-low point is reached after four accepted requests, and a read bounced by CRS can be seen overtaking nothing queued ahead of it. The timeout limit is set to 4 at run time, so the last accepted completion cycle, the first rejected one, the exact timeout edge and a timer restart after a retried write all fall within a few cycles. The header sweep runs every request kind against both directions, over three address patterns and three completion delays.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
  localparam int unsigned TAG_W = 8;

  typedef enum logic [1:0] {
    KIND_CFG0 = 2'd0,
    KIND_CFG1 = 2'd1,
    KIND_IO   = 2'd2
  } req_kind_e;

  localparam logic [2:0] CST_SC  = 3'b000;
  localparam logic [2:0] CST_UR  = 3'b001;
  localparam logic [2:0] CST_CRS = 3'b010;
  localparam logic [2:0] CST_CA  = 3'b100;

  localparam logic [4:0] HTYPE_CFG0 = 5'b00100;
  localparam logic [4:0] HTYPE_CFG1 = 5'b00101;
  localparam logic [4:0] HTYPE_IO   = 5'b00010;

  localparam logic [2:0] HFMT_RD = 3'b000;
  localparam logic [2:0] HFMT_WR = 3'b010;

  typedef struct packed {
    req_kind_e        kind;
    logic             write;
    logic [7:0]       bus;
    logic [4:0]       dev;
    logic [2:0]       func;
    logic [9:0]       regn;
    logic [TAG_W-1:0] tag;
    logic [31:0]      data;
  } req_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_RETRY,
    S_RESPOND
  } fsm_e;
endpackage

// File: rtl/cfgser_fifo.sv
module cfgser_fifo
  import cfgser_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  req_t             push_data_i,
  input  logic             pop_i,
  output req_t             pop_data_o,
  output logic [CNT_W-1:0] count_o
);
  req_t             mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr_q] <= push_data_i;
  end

  assign pop_data_o = mem[rd_ptr_q];
  assign count_o    = count_q;

  a_r12_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (count_q < CNT_W'(DEPTH)) || pop_i);
  a_r12_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_q != '0);
endmodule

// File: rtl/cfgser_hdr.sv
module cfgser_hdr
  import cfgser_pkg::*;
(
  input  req_t             req_i,
  output logic [2:0]       fmt_o,
  output logic [4:0]       type_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [31:0]      addr_o,
  output logic [31:0]      data_o
);
  always_comb begin
    unique case (req_i.kind)
      KIND_CFG0: type_o = HTYPE_CFG0;
      KIND_CFG1: type_o = HTYPE_CFG1;
      default:   type_o = HTYPE_IO;
    endcase
  end

  assign fmt_o  = req_i.write ? HFMT_WR : HFMT_RD;
  assign tag_o  = req_i.tag;
  assign addr_o = {req_i.bus, req_i.dev, req_i.func, 4'b0000, req_i.regn, 2'b00};
  assign data_o = req_i.write ? req_i.data : 32'h0;
endmodule

// File: rtl/cfgser_timer.sv
module cfgser_timer #(
  parameter int unsigned TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            run_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expired_o
);
  logic [TO_W-1:0] elapsed_q;
  logic [TO_W-1:0] last_idx;

  // a zero limit behaves as one cycle
  assign last_idx  = (limit_i == '0) ? '0 : limit_i - TO_W'(1);
  assign expired_o = run_i && (elapsed_q >= last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    elapsed_q <= '0;
    else if (start_i)               elapsed_q <= '0;
    else if (run_i && !expired_o)   elapsed_q <= elapsed_q + TO_W'(1);
  end
endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer
  import cfgser_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TO_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rc_mode_i,
  input  logic [TO_W-1:0]  cpl_timeout_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_kind_i,
  input  logic             req_write_i,
  input  logic [7:0]       req_bus_i,
  input  logic [4:0]       req_dev_i,
  input  logic [2:0]       req_func_i,
  input  logic [9:0]       req_reg_i,
  input  logic [7:0]       req_tag_i,
  input  logic [31:0]      req_data_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [2:0]       tx_fmt_o,
  output logic [4:0]       tx_type_o,
  output logic [7:0]       tx_tag_o,
  output logic [31:0]      tx_addr_o,
  output logic [31:0]      tx_data_o,
  input  logic             cpl_valid_i,
  input  logic [7:0]       cpl_tag_i,
  input  logic [2:0]       cpl_status_i,
  input  logic [31:0]      cpl_data_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [7:0]       rsp_tag_o,
  output logic [2:0]       rsp_status_o,
  output logic [31:0]      rsp_data_o,
  output logic             rsp_timeout_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  fsm_e             state_q;
  req_t             act_q, req_in, head, push_data;
  logic [CNT_W-1:0] fifo_cnt;
  logic [CNT_W:0]   occupied;
  logic             busy, push, pop, requeue, head_cfg, cpl_hit, tmr_start, tmr_expired;
  logic [7:0]       rsp_tag_q;
  logic [2:0]       rsp_status_q;
  logic [31:0]      rsp_data_q;
  logic             rsp_to_q;

  assign req_in = '{kind: req_kind_e'(req_kind_i), write: req_write_i, bus: req_bus_i,
                    dev: req_dev_i, func: req_func_i, regn: req_reg_i, tag: req_tag_i,
                    data: req_data_i};

  // one slot stays reserved for the in-flight request so a CRS read can always requeue
  assign busy        = state_q != S_IDLE;
  assign occupied    = {1'b0, fifo_cnt} + {{CNT_W{1'b0}}, busy};
  assign req_ready_o = (state_q != S_RETRY) && (occupied < (CNT_W+1)'(DEPTH));

  assign requeue   = (state_q == S_RETRY) && !act_q.write;
  assign push      = (req_valid_i && req_ready_o) || requeue;
  assign push_data = requeue ? act_q : req_in;
  assign pop       = (state_q == S_IDLE) && (fifo_cnt != '0);
  assign head_cfg  = (head.kind == KIND_CFG0) || (head.kind == KIND_CFG1);
  assign cpl_hit   = (state_q == S_WAIT) && cpl_valid_i && (cpl_tag_i == act_q.tag);
  assign tmr_start = (state_q == S_ISSUE) && tx_ready_i;

  cfgser_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .pop_data_o  (head),
    .count_o     (fifo_cnt)
  );

  cfgser_hdr u_hdr (
    .req_i  (act_q),
    .fmt_o  (tx_fmt_o),
    .type_o (tx_type_o),
    .tag_o  (tx_tag_o),
    .addr_o (tx_addr_o),
    .data_o (tx_data_o)
  );

  cfgser_timer #(.TO_W(TO_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (tmr_start),
    .run_i     (state_q == S_WAIT),
    .limit_i   (cpl_timeout_i),
    .expired_o (tmr_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      act_q        <= '0;
      rsp_tag_q    <= '0;
      rsp_status_q <= CST_SC;
      rsp_data_q   <= '0;
      rsp_to_q     <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (pop) begin
            act_q <= head;
            if (!rc_mode_i && head_cfg) begin
              rsp_tag_q    <= head.tag;
              rsp_status_q <= CST_UR;
              rsp_data_q   <= '0;
              rsp_to_q     <= 1'b0;
              state_q      <= S_RESPOND;
            end else begin
              state_q <= S_ISSUE;
            end
          end
        end
        S_ISSUE: if (tx_ready_i) state_q <= S_WAIT;
        S_WAIT: begin
          if (cpl_hit) begin
            if (cpl_status_i == CST_CRS) begin
              state_q <= S_RETRY;
            end else begin
              rsp_tag_q    <= act_q.tag;
              rsp_status_q <= cpl_status_i;
              rsp_data_q   <= (cpl_status_i == CST_SC && !act_q.write) ? cpl_data_i : '0;
              rsp_to_q     <= 1'b0;
              state_q      <= S_RESPOND;
            end
          end else if (tmr_expired) begin
            rsp_tag_q    <= act_q.tag;
            rsp_status_q <= CST_CA;
            rsp_data_q   <= '0;
            rsp_to_q     <= 1'b1;
            state_q      <= S_RESPOND;
          end
        end
        S_RETRY:   state_q <= act_q.write ? S_ISSUE : S_IDLE;
        S_RESPOND: if (rsp_ready_i) state_q <= S_IDLE;
        default:   state_q <= S_IDLE;
      endcase
    end
  end

  assign tx_valid_o    = state_q == S_ISSUE;
  assign rsp_valid_o   = state_q == S_RESPOND;
  assign rsp_tag_o     = rsp_tag_q;
  assign rsp_status_o  = rsp_status_q;
  assign rsp_data_o    = rsp_data_q;
  assign rsp_timeout_o = rsp_to_q;

  a_r4_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_addr_o) && $stable(tx_type_o)
                                  && $stable(tx_tag_o) && $stable(tx_fmt_o) && $stable(tx_data_o));
  a_r5_single_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i |=> !tx_valid_o);
  a_r6_no_crs_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_status_o != CST_CRS);
  a_r7_write_reissue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RETRY) && act_q.write |=> tx_valid_o);
  a_r9_timeout_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT) && !cpl_hit && tmr_expired |=> rsp_valid_o && rsp_timeout_o);
  a_r10_ep_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop && !rc_mode_i && head_cfg |=> rsp_valid_o && !tx_valid_o && rsp_status_o == CST_UR);
  a_r11_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_tag_o) && $stable(rsp_status_o)
                                    && $stable(rsp_data_o));
endmodule

// File: tb/cfg_serializer_bench.sv
module cfg_serializer_bench;
  localparam int DEPTH = 4;
  localparam int TO_W  = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, rc_mode;
  logic [TO_W-1:0] tmo;
  logic            req_valid, req_ready, req_write;
  logic [1:0]      req_kind;
  logic [7:0]      req_bus, req_tag;
  logic [4:0]      req_dev;
  logic [2:0]      req_func;
  logic [9:0]      req_reg;
  logic [31:0]     req_data;
  logic            tx_valid, tx_rdy;
  logic [2:0]      tx_fmt;
  logic [4:0]      tx_type;
  logic [7:0]      tx_tag;
  logic [31:0]     tx_addr, tx_data;
  logic            cpl_v;
  logic [7:0]      cpl_tag;
  logic [2:0]      cpl_st;
  logic [31:0]     cpl_data;
  logic            rsp_valid, rsp_rdy, rsp_to;
  logic [7:0]      rsp_tag;
  logic [2:0]      rsp_st;
  logic [31:0]     rsp_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  cfg_serializer #(.DEPTH(DEPTH), .TO_W(TO_W)) u_cfg_serializer (
    .clk_i(clk), .rst_ni(rst_n), .rc_mode_i(rc_mode), .cpl_timeout_i(tmo),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_kind_i(req_kind),
    .req_write_i(req_write), .req_bus_i(req_bus), .req_dev_i(req_dev),
    .req_func_i(req_func), .req_reg_i(req_reg), .req_tag_i(req_tag), .req_data_i(req_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_rdy), .tx_fmt_o(tx_fmt), .tx_type_o(tx_type),
    .tx_tag_o(tx_tag), .tx_addr_o(tx_addr), .tx_data_o(tx_data),
    .cpl_valid_i(cpl_v), .cpl_tag_i(cpl_tag), .cpl_status_i(cpl_st), .cpl_data_i(cpl_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_rdy), .rsp_tag_o(rsp_tag),
    .rsp_status_o(rsp_st), .rsp_data_o(rsp_data), .rsp_timeout_o(rsp_to)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_type(input logic [1:0] k);
    return (k == 2'd0) ? 5'b00100 : (k == 2'd1) ? 5'b00101 : 5'b00010;
  endfunction

  task automatic push(input logic [1:0] k, input bit wr, input logic [7:0] b, input logic [4:0] d,
                      input logic [2:0] f, input logic [9:0] r, input logic [7:0] t,
                      input logic [31:0] dat);
    @(negedge clk);
    req_kind = k; req_write = wr; req_bus = b; req_dev = d; req_func = f;
    req_reg = r; req_tag = t; req_data = dat; req_valid = 1'b1;
    for (int w = 0; w < 100 && !req_ready; w++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_tx(input logic [1:0] k, input bit wr, input logic [7:0] b,
                           input logic [4:0] d, input logic [2:0] f, input logic [9:0] r,
                           input logic [7:0] t, input logic [31:0] dat);
    for (int w = 0; w < 60 && !tx_valid; w++) @(negedge clk);
    chk("R5 tx offered", tx_valid, 1);
    chk("R1 type", tx_type, exp_type(k));
    chk("R2 fmt", tx_fmt, wr ? 3'b010 : 3'b000);
    chk("R2 data", tx_data, wr ? dat : 32'h0);
    chk("R3 addr", tx_addr, {b, d, f, 4'b0000, r, 2'b00});
    chk("R3 tag", tx_tag, t);
    tx_rdy = 1'b1;
    @(negedge clk);
    tx_rdy = 1'b0;
  endtask

  task automatic do_cpl(input logic [7:0] t, input logic [2:0] s, input logic [31:0] dat,
                        input int k);
    repeat (k) @(negedge clk);
    cpl_tag = t; cpl_st = s; cpl_data = dat; cpl_v = 1'b1;
    @(negedge clk);
    cpl_v = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic [7:0] t, input logic [2:0] s,
                            input logic [31:0] dat, input bit to);
    for (int w = 0; w < 60 && !rsp_valid; w++) @(negedge clk);
    chk({req, " rsp valid"}, rsp_valid, 1);
    chk({req, " rsp tag"}, rsp_tag, t);
    chk({req, " rsp status"}, rsp_st, s);
    chk({req, " rsp data"}, rsp_data, dat);
    chk({req, " rsp timeout"}, rsp_to, to);
    rsp_rdy = 1'b1;
    @(negedge clk);
    rsp_rdy = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rc_mode = 1'b1; tmo = 8'd20;
    req_valid = 1'b0; req_kind = '0; req_write = 1'b0; req_bus = '0; req_dev = '0;
    req_func = '0; req_reg = '0; req_tag = '0; req_data = '0;
    tx_rdy = 1'b0; cpl_v = 1'b0; cpl_tag = '0; cpl_st = '0; cpl_data = '0; rsp_rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 tx_valid", tx_valid, 0);
    chk("R13 rsp_valid", rsp_valid, 0);
    chk("R13 req_ready", req_ready, 1);

    // R1 R2 R3 R11 sweep: all kinds, both directions, three address patterns and delays
    for (int k = 0; k < 3; k++) begin
      for (int wr = 0; wr < 2; wr++) begin
        for (int p = 0; p < 3; p++) begin
          logic [7:0]  b, t;
          logic [4:0]  d;
          logic [2:0]  f;
          logic [9:0]  r;
          logic [31:0] dat, cd;
          b = 8'(8'h11 * (p + 1) + k);
          d = 5'(p * 7 + wr * 3 + 1);
          f = 3'(p + k);
          r = 10'(10'h3FF - p * 10'h155);
          t = 8'(k * 16 + wr * 8 + p);
          dat = 32'hA500_0000 | 32'(t);
          cd = ~dat;
          push(2'(k), wr[0], b, d, f, r, t, dat);
          expect_tx(2'(k), wr[0], b, d, f, r, t, dat);
          do_cpl(t, 3'b000, cd, p);
          expect_rsp("R11", t, 3'b000, wr[0] ? 32'h0 : cd, 1'b0);
        end
      end
    end

    // R4: header held while downstream stalls
    push(2'd1, 1'b1, 8'h3C, 5'h1E, 3'h5, 10'h2C1, 8'hA1, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk("R4 held valid", tx_valid, 1);
      chk("R4 held addr", tx_addr, {8'h3C, 5'h1E, 3'h5, 4'b0, 10'h2C1, 2'b00});
      @(negedge clk);
    end
    expect_tx(2'd1, 1'b1, 8'h3C, 5'h1E, 3'h5, 10'h2C1, 8'hA1, 32'hDEAD_BEEF);
    do_cpl(8'hA1, 3'b001, 32'h1234, 0);
    expect_rsp("R11 UR", 8'hA1, 3'b001, 32'h0, 1'b0);

    // R5: a queued request waits for the outstanding write and its response
    push(2'd2, 1'b1, 8'h01, 5'h02, 3'h3, 10'h004, 8'hB0, 32'h5555_0001);
    push(2'd0, 1'b0, 8'h07, 5'h08, 3'h1, 10'h010, 8'hB1, 32'h0);
    expect_tx(2'd2, 1'b1, 8'h01, 5'h02, 3'h3, 10'h004, 8'hB0, 32'h5555_0001);
    begin
      bit leak = 1'b0;
      for (int i = 0; i < 8; i++) begin
        if (tx_valid) leak = 1'b1;
        @(negedge clk);
      end
      chk("R5 no tx while waiting", leak, 0);
      do_cpl(8'hB0, 3'b000, 32'h0, 0);
      for (int i = 0; i < 3; i++) begin
        if (tx_valid) leak = 1'b1;
        @(negedge clk);
      end
      chk("R5 no tx while response pending", leak, 0);
      chk("R11 response held", rsp_valid, 1);
    end
    expect_rsp("R5", 8'hB0, 3'b000, 32'h0, 1'b0);
    expect_tx(2'd0, 1'b0, 8'h07, 5'h08, 3'h1, 10'h010, 8'hB1, 32'h0);
    do_cpl(8'hB1, 3'b000, 32'hCAFE_0001, 1);
    expect_rsp("R5", 8'hB1, 3'b000, 32'hCAFE_0001, 1'b0);

    // R6: completion with another tag is dropped
    push(2'd0, 1'b0, 8'h20, 5'h04, 3'h2, 10'h0FF, 8'h60, 32'h0);
    expect_tx(2'd0, 1'b0, 8'h20, 5'h04, 3'h2, 10'h0FF, 8'h60, 32'h0);
    do_cpl(8'h61, 3'b000, 32'h7777, 0);
    chk("R6 wrong tag no rsp", rsp_valid, 0);
    @(negedge clk);
    chk("R6 wrong tag no rsp later", rsp_valid, 0);
    do_cpl(8'h60, 3'b100, 32'h7777, 0);
    expect_rsp("R6 CA", 8'h60, 3'b100, 32'h0, 1'b0);

    // R7: CRS on a write reissues; timer restarts each time (limit 4, reply in 4th cycle)
    tmo = 8'd4;
    push(2'd1, 1'b1, 8'h55, 5'h0A, 3'h6, 10'h155, 8'h50, 32'h0BAD_F00D);
    expect_tx(2'd1, 1'b1, 8'h55, 5'h0A, 3'h6, 10'h155, 8'h50, 32'h0BAD_F00D);
    do_cpl(8'h50, 3'b010, 32'h0, 3);
    expect_tx(2'd1, 1'b1, 8'h55, 5'h0A, 3'h6, 10'h155, 8'h50, 32'h0BAD_F00D);
    do_cpl(8'h50, 3'b010, 32'h0, 3);
    expect_tx(2'd1, 1'b1, 8'h55, 5'h0A, 3'h6, 10'h155, 8'h50, 32'h0BAD_F00D);
    do_cpl(8'h50, 3'b000, 32'h0, 3);
    expect_rsp("R7", 8'h50, 3'b000, 32'h0, 1'b0);
    push(2'd0, 1'b1, 8'h56, 5'h0B, 3'h0, 10'h001, 8'h51, 32'h1111_2222);
    expect_tx(2'd0, 1'b1, 8'h56, 5'h0B, 3'h0, 10'h001, 8'h51, 32'h1111_2222);
    do_cpl(8'h51, 3'b010, 32'h0, 0);
    expect_tx(2'd0, 1'b1, 8'h56, 5'h0B, 3'h0, 10'h001, 8'h51, 32'h1111_2222);
    expect_rsp("R7 R9 retry timeout", 8'h51, 3'b100, 32'h0, 1'b1);

    // R8: CRS on a read sends it behind the queued read
    tmo = 8'd20;
    push(2'd0, 1'b0, 8'h41, 5'h01, 3'h1, 10'h041, 8'h41, 32'h0);
    push(2'd1, 1'b0, 8'h42, 5'h02, 3'h2, 10'h042, 8'h42, 32'h0);
    expect_tx(2'd0, 1'b0, 8'h41, 5'h01, 3'h1, 10'h041, 8'h41, 32'h0);
    do_cpl(8'h41, 3'b010, 32'h0, 0);
    chk("R8 no rsp for CRS read", rsp_valid, 0);
    expect_tx(2'd1, 1'b0, 8'h42, 5'h02, 3'h2, 10'h042, 8'h42, 32'h0);
    do_cpl(8'h42, 3'b000, 32'h4242_4242, 0);
    expect_rsp("R8 second first", 8'h42, 3'b000, 32'h4242_4242, 1'b0);
    expect_tx(2'd0, 1'b0, 8'h41, 5'h01, 3'h1, 10'h041, 8'h41, 32'h0);
    do_cpl(8'h41, 3'b000, 32'h4141_4141, 0);
    expect_rsp("R8 requeued last", 8'h41, 3'b000, 32'h4141_4141, 1'b0);

    // R9: limit 4 boundaries
    tmo = 8'd4;
    push(2'd0, 1'b0, 8'h90, 5'h10, 3'h0, 10'h090, 8'h90, 32'h0);
    expect_tx(2'd0, 1'b0, 8'h90, 5'h10, 3'h0, 10'h090, 8'h90, 32'h0);
    do_cpl(8'h90, 3'b000, 32'h9090, 3);
    expect_rsp("R9 last cycle accepted", 8'h90, 3'b000, 32'h9090, 1'b0);
    push(2'd0, 1'b0, 8'h91, 5'h11, 3'h0, 10'h091, 8'h91, 32'h0);
    expect_tx(2'd0, 1'b0, 8'h91, 5'h11, 3'h0, 10'h091, 8'h91, 32'h0);
    do_cpl(8'h91, 3'b000, 32'h9191, 4);
    expect_rsp("R9 late rejected", 8'h91, 3'b100, 32'h0, 1'b1);
    push(2'd2, 1'b0, 8'h92, 5'h12, 3'h0, 10'h092, 8'h92, 32'h0);
    expect_tx(2'd2, 1'b0, 8'h92, 5'h12, 3'h0, 10'h092, 8'h92, 32'h0);
    repeat (3) @(negedge clk);
    chk("R9 not yet timed out", rsp_valid, 0);
    @(negedge clk);
    chk("R9 timeout edge", rsp_valid, 1);
    expect_rsp("R9", 8'h92, 3'b100, 32'h0, 1'b1);
    tmo = 8'd0;
    push(2'd0, 1'b0, 8'h93, 5'h13, 3'h0, 10'h093, 8'h93, 32'h0);
    expect_tx(2'd0, 1'b0, 8'h93, 5'h13, 3'h0, 10'h093, 8'h93, 32'h0);
    @(negedge clk);
    chk("R9 zero limit acts as one", rsp_valid, 1);
    expect_rsp("R9 zero", 8'h93, 3'b100, 32'h0, 1'b1);

    // R10: endpoint mode refuses configuration, passes I/O
    tmo = 8'd20;
    rc_mode = 1'b0;
    push(2'd0, 1'b0, 8'hE0, 5'h0E, 3'h7, 10'h3E0, 8'hE0, 32'h0);
    expect_rsp("R10 cfg0", 8'hE0, 3'b001, 32'h0, 1'b0);
    chk("R10 no header", tx_valid, 0);
    push(2'd1, 1'b1, 8'hE1, 5'h0F, 3'h6, 10'h3E1, 8'hE1, 32'hE1E1);
    expect_rsp("R10 cfg1", 8'hE1, 3'b001, 32'h0, 1'b0);
    chk("R10 no header", tx_valid, 0);
    push(2'd2, 1'b1, 8'hE2, 5'h01, 3'h1, 10'h3E2, 8'hE2, 32'hE2E2_E2E2);
    expect_tx(2'd2, 1'b1, 8'hE2, 5'h01, 3'h1, 10'h3E2, 8'hE2, 32'hE2E2_E2E2);
    do_cpl(8'hE2, 3'b000, 32'h0, 0);
    expect_rsp("R10 io", 8'hE2, 3'b000, 32'h0, 1'b0);
    rc_mode = 1'b1;

    // R12: capacity and arrival order
    begin
      int acc = 0;
      @(negedge clk);
      req_kind = 2'd1; req_write = 1'b0; req_bus = 8'h70; req_dev = 5'h07;
      req_func = 3'h0; req_reg = 10'h070; req_data = '0; req_tag = 8'h70; req_valid = 1'b1;
      for (int c = 0; c < 10; c++) begin
        if (req_ready) acc++;
        @(negedge clk);
        req_tag = 8'(8'h70 + acc);
      end
      req_valid = 1'b0;
      chk("R12 accepted count", acc, DEPTH);
      chk("R12 ready low when full", req_ready, 0);
      for (int i = 0; i < DEPTH; i++) begin
        expect_tx(2'd1, 1'b0, 8'h70, 5'h07, 3'h0, 10'h070, 8'(8'h70 + i), 32'h0);
        do_cpl(8'(8'h70 + i), 3'b000, 32'(i), 0);
        expect_rsp("R12 order", 8'(8'h70 + i), 3'b000, 32'(i), 1'b0);
      end
      chk("R12 ready after drain", req_ready, 1);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule